// File: doc/BRIEF.md
# eMMC Bus Mode and Sampling Tap Control Register

This block is a 32-bit host control register for an eMMC host. One field picks the bus speed mode that the rest of the host follows. A second field holds a receive sampling tap for the input delay line. A third bit is a self-clearing request that commits the tap to the datapath. Software writes a new tap with the request bit set. It then polls until the bit reads back as zero, which happens after a fixed settle window. Only at that moment does the tap output to the delay line change.

Not every tap code is usable on the delay line. The block folds each stored tap into the usable range of 0 to 42 before driving it out, so a code of 43 lands on 0. The raw value stays readable. An enhanced-strobe control input can flip the mode between plain HS400 and HS400 with enhanced strobe without a software write. Mode codes that have no meaning are refused, and the old mode is kept.

Top module: `emmc_mode_tune_reg`

## Requirements
- R1: After reset, the read word, the mode output and the tap output are all zero. A write whose bits 2:0 hold a legal code sets the mode, which appears on `mode_o` and in read bits 2:0 one cycle later. The legal codes are 0 (SD), 2 (MMC SDR), 3 (MMC DDR), 4 (HS200), 5 (HS400) and 6 (HS400 enhanced strobe).
- R2: A write whose bits 2:0 hold code 1 or code 7 leaves the mode unchanged.
- R3: Every write stores bits 13:8 as the raw tap, readable at read bits 13:8. A write with bit 15 clear does not change `tap_o`.
- R4: A write with bit 15 set makes read bit 15 show 1 for exactly SETTLE_CYCLES cycles (default 4). After that the bit reads 0.
- R5: `tap_o` changes only in the cycle in which read bit 15 returns to 0. It then takes the folded value of the stored raw tap.
- R6: The folded tap is the raw tap modulo 43, so 42 gives 42, 43 gives 0 and 63 gives 20. `tap_o` never exceeds 42.
- R7: A rising edge of `strobe_en` while the mode is 5 changes the mode to 6. A falling edge while the mode is 6 changes it to 5.
- R8: A `strobe_en` edge in any other mode has no effect. A steady `strobe_en` level, high or low, never changes the mode.
- R9: When a mode write and a `strobe_en` edge fall in the same cycle, the swap acts on the written code. Writing 5 with a rising edge gives 6, and writing 6 with a falling edge gives 5.
- R10: A write with bit 15 set while an update is pending restarts the full settle window. When the window ends, the tap applied is the latest stored one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write word |
| rd_data | output | 32 | Register read word: mode in 2:0, raw tap in 13:8, update pending in 15, all other bits zero |
| strobe_en | input | 1 | Enhanced-strobe setting |
| mode_o | output | 3 | Bus speed mode in use |
| tap_o | output | 6 | Applied, folded sampling tap to the delay line |

## Verification
A software mode write and an edge of the enhanced-strobe input can reach the mode field in the same clock. The bench provokes this by driving the write strobe and the strobe transition in the same cycle. It does this once as a rising edge with code 5 and once as a falling edge with code 6. The bench judges the result by the mode one cycle later, which must be the swapped code. A second overlap is a new update request that arrives while an earlier one is still settling. That case is judged by the length of the pending window and by which tap finally reaches the output.

// File: rtl/emmc_ctl_pkg.sv
package emmc_ctl_pkg;

    typedef enum logic [2:0] {
        BM_SD       = 3'd0,
        BM_RSV_LO   = 3'd1,
        BM_MMC_SDR  = 3'd2,
        BM_MMC_DDR  = 3'd3,
        BM_HS200    = 3'd4,
        BM_HS400    = 3'd5,
        BM_HS400_ES = 3'd6,
        BM_RSV_HI   = 3'd7
    } bus_mode_e;

    localparam int MODE_W   = 3;
    localparam int MODE_LSB = 0;
    localparam int TAP_LSB  = 8;
    localparam int UPD_POS  = 15;

    function automatic logic mode_code_ok(input logic [MODE_W-1:0] code);
        return !(code == BM_RSV_LO || code == BM_RSV_HI);
    endfunction

endpackage

// File: rtl/emmc_mode_sel.sv
module emmc_mode_sel
    import emmc_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_code,
    input  logic              strobe_en,
    output logic [MODE_W-1:0] mode_o
);

    bus_mode_e mode_q, base_mode, mode_d;
    logic      strobe_q;
    logic      strobe_rise, strobe_fall, take_wr;

    assign strobe_rise = strobe_en & ~strobe_q;
    assign strobe_fall = ~strobe_en & strobe_q;
    assign take_wr     = wr_en & mode_code_ok(wr_code);

    always_comb begin
        base_mode = take_wr ? bus_mode_e'(wr_code) : mode_q;
        mode_d    = base_mode;
        if (strobe_rise && base_mode == BM_HS400)
            mode_d = BM_HS400_ES;
        else if (strobe_fall && base_mode == BM_HS400_ES)
            mode_d = BM_HS400;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= BM_SD;
            strobe_q <= 1'b0;
        end else begin
            mode_q   <= mode_d;
            strobe_q <= strobe_en;
        end
    end

    assign mode_o = mode_q;

    // R2: a reserved code is never held
    a_r2_no_reserved: assert property (@(posedge clk) disable iff (rst)
        mode_code_ok(mode_q));

    // R7: rising strobe edge in HS400 moves to the strobe variant
    a_r7_swap_up: assert property (@(posedge clk) disable iff (rst)
        (strobe_rise && !wr_en && mode_q == BM_HS400) |=> (mode_q == BM_HS400_ES));

    // R8: no write and no strobe edge keeps the mode
    a_r8_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && strobe_en == strobe_q) |=> $stable(mode_q));

    // R9: write of HS400 with a rising edge in the same cycle ends in the strobe variant
    a_r9_same_cycle: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_code == BM_HS400 && strobe_rise) |=> (mode_q == BM_HS400_ES));

endmodule

// File: rtl/emmc_tap_update.sv
module emmc_tap_update #(
    parameter int TAP_W         = 6,
    parameter int TAP_LIMIT     = 43,
    parameter int SETTLE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [TAP_W-1:0] wr_tap,
    input  logic             wr_upd,
    output logic [TAP_W-1:0] tap_field,
    output logic             upd_pending,
    output logic [TAP_W-1:0] tap_applied
);

    localparam int             CNT_W   = $clog2(SETTLE_CYCLES + 1);
    localparam logic [TAP_W-1:0] LIMIT_V = TAP_W'(TAP_LIMIT);
    localparam logic [CNT_W-1:0] RELOAD  = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] settle_cnt;
    logic [TAP_W-1:0] tap_folded;
    logic             start_upd;

    assign start_upd  = wr_en & wr_upd;
    assign tap_folded = tap_field % LIMIT_V;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_field   <= '0;
            upd_pending <= 1'b0;
            settle_cnt  <= '0;
            tap_applied <= '0;
        end else begin
            if (wr_en)
                tap_field <= wr_tap;
            if (start_upd) begin
                upd_pending <= 1'b1;
                settle_cnt  <= RELOAD;
            end else if (upd_pending) begin
                if (settle_cnt == '0) begin
                    upd_pending <= 1'b0;
                    tap_applied <= tap_folded;
                end else begin
                    settle_cnt <= settle_cnt - 1'b1;
                end
            end
        end
    end

    // R6: the tap driven to the delay line stays in the usable range
    a_r6_tap_in_range: assert property (@(posedge clk) disable iff (rst)
        tap_applied < LIMIT_V);

    // R5: the applied tap moves only when the pending bit drops
    a_r5_apply_on_clear: assert property (@(posedge clk) disable iff (rst)
        !$stable(tap_applied) |-> $fell(upd_pending));

    // R4: the settle counter never exceeds its window
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        upd_pending |-> (settle_cnt <= RELOAD));

    // R10: a new request always reopens a full window
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        start_upd |=> (upd_pending && settle_cnt == RELOAD));

endmodule

// File: rtl/emmc_mode_tune_reg.sv
module emmc_mode_tune_reg
    import emmc_ctl_pkg::*;
#(
    parameter int TAP_W         = 6,
    parameter int TAP_LIMIT     = 43,
    parameter int SETTLE_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        strobe_en,
    output logic [2:0]  mode_o,
    output logic [5:0]  tap_o
);

    localparam logic [31:0] USED_MASK =
        (32'((1 << MODE_W) - 1) << MODE_LSB) |
        (32'((1 << TAP_W) - 1) << TAP_LSB) |
        (32'd1 << UPD_POS);

    logic [TAP_W-1:0]  tap_raw, tap_drv;
    logic              pending;
    logic [MODE_W-1:0] mode_cur;
    logic [31:0]       wr_unused_bits;

    assign wr_unused_bits = wr_data & ~USED_MASK;

    emmc_mode_sel u_mode (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_code   (wr_data[MODE_LSB +: MODE_W]),
        .strobe_en (strobe_en),
        .mode_o    (mode_cur)
    );

    emmc_tap_update #(
        .TAP_W         (TAP_W),
        .TAP_LIMIT     (TAP_LIMIT),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_tap (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_tap      (wr_data[TAP_LSB +: TAP_W]),
        .wr_upd      (wr_data[UPD_POS]),
        .tap_field   (tap_raw),
        .upd_pending (pending),
        .tap_applied (tap_drv)
    );

    always_comb begin
        rd_data                     = '0;
        rd_data[MODE_LSB +: MODE_W] = mode_cur;
        rd_data[TAP_LSB +: TAP_W]   = tap_raw;
        rd_data[UPD_POS]            = pending;
    end

    assign mode_o = mode_cur;
    assign tap_o  = tap_drv;

endmodule

// File: tb/emmc_mode_tune_reg_tb.sv
module emmc_mode_tune_reg_tb_top;

    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        strobe_en = 1'b0;
    logic [31:0] rd_data;
    logic [2:0]  mode_o;
    logic [5:0]  tap_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    emmc_mode_tune_reg #(.SETTLE_CYCLES(SETTLE)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .strobe_en(strobe_en), .mode_o(mode_o), .tap_o(tap_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int mode, input int tap, input bit upd);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 32'(mode & 7) | (32'(tap & 63) << 8) | (32'(upd) << 15);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_strobe(input bit v);
        @(negedge clk);
        strobe_en = v;
        @(negedge clk);
    endtask

    task automatic expect_apply(input int exp_tap, input int old_tap, input string req);
        chk(rd_data[15] == 1'b1, "R4 pending set", int'(rd_data[15]), 1);
        for (int k = 1; k < SETTLE; k++) begin
            @(negedge clk);
            chk(rd_data[15] == 1'b1, "R4 pending held", int'(rd_data[15]), 1);
            chk(tap_o == 6'(old_tap), "R5 tap not yet applied", int'(tap_o), old_tap);
        end
        @(negedge clk);
        chk(rd_data[15] == 1'b0, "R4 pending cleared", int'(rd_data[15]), 0);
        chk(tap_o == 6'(exp_tap), req, int'(tap_o), exp_tap);
    endtask

    task automatic t_reset();
        chk(rd_data == 32'd0, "R1 reset read word", int'(rd_data), 0);
        chk(mode_o == 3'd0, "R1 reset mode", int'(mode_o), 0);
        chk(tap_o == 6'd0, "R1 reset tap", int'(tap_o), 0);
    endtask

    task automatic t_modes();
        int codes[6] = '{0, 2, 3, 4, 5, 6};
        foreach (codes[i]) begin
            wr(codes[i], 0, 1'b0);
            chk(mode_o == 3'(codes[i]), "R1 mode output", int'(mode_o), codes[i]);
            chk(rd_data[2:0] == 3'(codes[i]), "R1 mode readback", int'(rd_data[2:0]), codes[i]);
        end
    endtask

    task automatic t_reserved();
        wr(4, 0, 1'b0);
        wr(1, 0, 1'b0);
        chk(mode_o == 3'd4, "R2 code 1 ignored", int'(mode_o), 4);
        wr(7, 0, 1'b0);
        chk(mode_o == 3'd4, "R2 code 7 ignored", int'(mode_o), 4);
    endtask

    task automatic t_tap_store();
        wr(7, 37, 1'b0);
        chk(rd_data[13:8] == 6'd37, "R3 raw tap stored", int'(rd_data[13:8]), 37);
        chk(rd_data[15] == 1'b0, "R3 no pending", int'(rd_data[15]), 0);
        repeat (SETTLE + 2) @(negedge clk);
        chk(tap_o == 6'd0, "R3 tap output unchanged", int'(tap_o), 0);
    endtask

    task automatic t_apply();
        wr(7, 20, 1'b1);
        expect_apply(20, 0, "R5 tap applied on clear");
    endtask

    task automatic t_wrap();
        wr(7, 43, 1'b1);
        expect_apply(0, 20, "R6 tap 43 folds to 0");
        wr(7, 63, 1'b1);
        chk(rd_data[13:8] == 6'd63, "R6 raw 63 readable", int'(rd_data[13:8]), 63);
        expect_apply(20, 0, "R6 tap 63 folds to 20");
        wr(7, 42, 1'b1);
        expect_apply(42, 20, "R6 tap 42 kept");
    endtask

    task automatic t_strobe();
        wr(5, 42, 1'b0);
        set_strobe(1'b1);
        chk(mode_o == 3'd6, "R7 rise in HS400", int'(mode_o), 6);
        set_strobe(1'b0);
        chk(mode_o == 3'd5, "R7 fall in HS400-ES", int'(mode_o), 5);
        wr(4, 42, 1'b0);
        set_strobe(1'b1);
        chk(mode_o == 3'd4, "R8 rise in HS200 ignored", int'(mode_o), 4);
        wr(5, 42, 1'b0);
        repeat (3) @(negedge clk);
        chk(mode_o == 3'd5, "R8 steady high level ignored", int'(mode_o), 5);
        wr(4, 42, 1'b0);
        set_strobe(1'b0);
        chk(mode_o == 3'd4, "R8 fall in HS200 ignored", int'(mode_o), 4);
    endtask

    task automatic t_collide();
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'd5 | (32'd42 << 8); strobe_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(mode_o == 3'd6, "R9 write 5 with rise", int'(mode_o), 6);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'd6 | (32'd42 << 8); strobe_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        chk(mode_o == 3'd5, "R9 write 6 with fall", int'(mode_o), 5);
    endtask

    task automatic t_restart();
        wr(7, 10, 1'b1);
        @(negedge clk);
        chk(tap_o == 6'd42, "R10 first tap not applied early", int'(tap_o), 42);
        wr(7, 30, 1'b1);
        expect_apply(30, 42, "R10 latest tap after restart");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_modes();
        t_reserved();
        t_tap_store();
        t_apply();
        t_wrap();
        t_strobe();
        t_collide();
        t_restart();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule